// File: doc/BRIEF.md
# Video-Mode Packet Header Scheduler

This block decides, line by line, which packet headers a display serial link master must send while it streams video. From a set of horizontal and vertical timing counts, a timing style, per-area skip flags, a virtual channel and a pixel format, it produces an endless ordered stream of packet descriptors, one frame after another. Each descriptor has an 8-bit data identifier, a 16-bit word count and a payload kind. A downstream packet builder uses the descriptor to attach the payload: nothing, blanking bytes, pixel bytes or null fill.

The descriptor output is a valid/ready stream. A descriptor is taken on every rising clock edge where `out_valid` and `out_ready` are both high, so the block can deliver one descriptor per cycle. While `out_valid` is high and `out_ready` is low, the descriptor on the port does not change. The `en` pin is a plain control input. Raising it starts the stream at the first line of a frame. Lowering it abandons the stream: `out_valid` falls one cycle later, even if a descriptor has not been taken. Configuration inputs must not change while `en` is high.

A line always starts with a sync-start packet and, unless suppressed, ends with an end-of-transmission packet. Between these come the horizontal blanking areas and the active-area packets for that line. Which ones appear depends on the timing style, the skip flags and the vertical region the line falls in.

Top module: `dvs_vid_sched`

## Requirements
- R1: Every data identifier carries `vc` in bits 7:6 and the 6-bit packet type in bits 5:0. Kind codes are 0 none, 1 blanking, 2 pixels, 3 null fill. Short packets have word count 0.
- R2: A line opens with a kind-none packet. Its type is 0x01 on the first vertical-sync line and 0x21 on every other line.
- R3: In sync-pulse styles (`mode[1]`=1), the opening packet is followed by an HSA blanking packet (type 0x19, word count `h_sync`), unless `skip_hsa` is set. An end packet comes next: type 0x11 on the last vertical-sync line, 0x31 otherwise.
- R4: In sync-event styles (`mode[1]`=0), no HSA blanking packet is sent. An end packet (same codes as R3) follows the opening packet only on vertical sync, back-porch and front-porch lines, and only when `hse` is set.
- R5: An active line then carries an HBP blanking packet (0x19, word count `h_bp`) unless `skip_hbp` is set, then the pixel packet, then an HFP blanking packet (0x19, word count `h_fp`) unless `skip_hfp` is set. Vertical blanking lines carry none of these.
- R6: The pixel packet type is 0x0E, 0x1E, 0x2E or 0x3E for `pix_fmt` 0..3 (16-bit, packed 18-bit, loose 18-bit, 24-bit). Its word count is `h_act` times 2, floor(`h_act`*9/4), times 3 and times 3 respectively, truncated to 16 bits.
- R7: In non-burst styles (`mode[0]`=0), a null packet (type 0x09, word count `fill_wc`, kind null) directly follows the pixel packet when `fill_wc` is non-zero. Burst styles (`mode[0]`=1) send no null packet.
- R8: Each line closes with type 0x08 unless `eot_off` is set. The next accepted descriptor then opens a new line.
- R9: Lines run through the regions sync (`v_sync` lines), back porch (`v_bp`), active (`v_act`, at least 1) and front porch (`v_fp`), then wrap to the next frame. Empty regions are skipped. With `auto_vcnt` set, the sync and back-porch regions are left out.
- R10: While `out_valid` is high and `out_ready` is low, the descriptor holds. Each handshake moves to the next descriptor in the following cycle.
- R11: With `en` low, `out_valid` is low in the next cycle. A later rise of `en` restarts at the first line of a frame.
- R12: After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low abandons the stream |
| mode | input | 2 | Bit 0 burst, bit 1 sync pulses |
| hse | input | 1 | Send end packet on vertical blanking lines in event styles |
| skip_hsa | input | 1 | Leave out HSA blanking |
| skip_hbp | input | 1 | Leave out HBP blanking |
| skip_hfp | input | 1 | Leave out HFP blanking |
| auto_vcnt | input | 1 | Bypass sync and back-porch line counts |
| eot_off | input | 1 | Suppress end-of-transmission packet |
| vc | input | 2 | Virtual channel |
| pix_fmt | input | 2 | Pixel format select |
| h_sync | input | 16 | HSA blanking byte count |
| h_bp | input | 16 | HBP blanking byte count |
| h_act | input | 16 | Active pixels per line |
| h_fp | input | 16 | HFP blanking byte count |
| v_sync | input | 12 | Vertical sync lines |
| v_bp | input | 12 | Vertical back-porch lines |
| v_act | input | 12 | Active lines |
| v_fp | input | 12 | Vertical front-porch lines |
| fill_wc | input | 16 | Null fill word count for non-burst styles |
| out_valid | output | 1 | Descriptor valid |
| out_ready | input | 1 | Descriptor accepted when high with valid |
| out_di | output | 8 | Data identifier |
| out_wc | output | 16 | Word count |
| out_kind | output | 2 | Payload kind |

## Verification
The embedded properties assume that all timing, mode and flag inputs stay constant while `en` is high, and that `v_act` is at least one. The auto-count and sync-style checks compare the current position against live configuration, so a mid-run change would trip them falsely. Each bench scenario therefore loads its settings while `en` is low and only then raises it. Back-pressure is applied through a periodic `out_ready` pattern, never through configuration changes, and the restart scenario lowers `en` only between handshakes.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
  typedef enum logic [2:0] {
    ST_START, ST_HSA, ST_END, ST_HBP, ST_PIX, ST_NULL, ST_HFP, ST_EOT
  } step_e;

  typedef enum logic [1:0] {
    RG_SYNC, RG_BPORCH, RG_ACT, RG_FPORCH
  } vreg_e;

  typedef enum logic [1:0] {
    K_NONE, K_BLANK, K_PIX, K_NULL
  } kind_e;

  localparam logic [5:0] T_VS_START = 6'h01;
  localparam logic [5:0] T_VS_END   = 6'h11;
  localparam logic [5:0] T_HS_START = 6'h21;
  localparam logic [5:0] T_HS_END   = 6'h31;
  localparam logic [5:0] T_EOT      = 6'h08;
  localparam logic [5:0] T_NULL     = 6'h09;
  localparam logic [5:0] T_BLANK    = 6'h19;
  localparam logic [3:0] T_PIX_LO   = 4'hE;
endpackage

// File: rtl/dvs_vline.sv
module dvs_vline
  import dvs_pkg::*;
#(
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic          auto_vcnt,
  input  logic [VW-1:0] v_sync,
  input  logic [VW-1:0] v_bp,
  input  logic [VW-1:0] v_act,
  input  logic [VW-1:0] v_fp,
  output logic          line_active,
  output logic          first_sync,
  output logic          last_sync
);
  localparam int NREG = 4;

  vreg_e         region;
  logic [VW-1:0] idx;
  logic [VW-1:0] lens [NREG];
  vreg_e         nxt_reg;
  vreg_e         top_reg;

  always_comb begin
    lens[0] = auto_vcnt ? '0 : v_sync;
    lens[1] = auto_vcnt ? '0 : v_bp;
    lens[2] = v_act;
    lens[3] = v_fp;
  end

  // first non-empty region after the current one (wrapping)
  always_comb begin
    logic       found;
    logic [1:0] cand;
    found   = 1'b0;
    nxt_reg = RG_ACT;
    for (int k = 1; k <= NREG; k++) begin
      cand = 2'(region) + 2'(k);
      if (!found && lens[cand] != '0) begin
        nxt_reg = vreg_e'(cand);
        found   = 1'b1;
      end
    end
  end

  // first non-empty region of a frame
  always_comb begin
    logic found;
    found   = 1'b0;
    top_reg = RG_ACT;
    for (int k = 0; k < NREG; k++) begin
      if (!found && lens[k] != '0) begin
        top_reg = vreg_e'(2'(k));
        found   = 1'b1;
      end
    end
  end

  logic [VW-1:0] cur_last;
  assign cur_last = lens[region] - VW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region <= RG_SYNC;
      idx    <= '0;
    end else if (clr) begin
      region <= top_reg;
      idx    <= '0;
    end else if (adv) begin
      if (idx >= cur_last) begin
        region <= nxt_reg;
        idx    <= '0;
      end else begin
        idx <= idx + VW'(1);
      end
    end
  end

  assign line_active = (region == RG_ACT);
  assign first_sync  = (region == RG_SYNC) && (idx == '0);
  assign last_sync   = (region == RG_SYNC) && (idx == lens[0] - VW'(1));

  // R9
  auto_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && auto_vcnt) |-> (region == RG_ACT || region == RG_FPORCH));
endmodule

// File: rtl/dvs_step.sv
module dvs_step
  import dvs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  fire,
  input  logic  pulse,
  input  logic  burst,
  input  logic  hse,
  input  logic  skip_hsa,
  input  logic  skip_hbp,
  input  logic  skip_hfp,
  input  logic  eot_off,
  input  logic  fill_nz,
  input  logic  line_active,
  output step_e step,
  output logic  line_done
);
  localparam int NSTEP = 8;

  logic [NSTEP-1:0] use_step;
  step_e            nxt;
  logic             more;

  always_comb begin
    use_step           = '0;
    use_step[ST_START] = 1'b1;
    use_step[ST_HSA]   = pulse && !skip_hsa;
    use_step[ST_END]   = pulse || (hse && !line_active);
    use_step[ST_HBP]   = line_active && !skip_hbp;
    use_step[ST_PIX]   = line_active;
    use_step[ST_NULL]  = line_active && !burst && fill_nz;
    use_step[ST_HFP]   = line_active && !skip_hfp;
    use_step[ST_EOT]   = !eot_off;
  end

  always_comb begin
    more = 1'b0;
    nxt  = ST_START;
    for (int k = 0; k < NSTEP; k++) begin
      if (!more && (k > int'(step)) && use_step[k]) begin
        nxt  = step_e'(3'(k));
        more = 1'b1;
      end
    end
  end

  assign line_done = fire && !more;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    step <= ST_START;
    else if (clr)  step <= ST_START;
    else if (fire) step <= nxt;
  end

  // R4
  event_no_hsa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !pulse) |-> (step != ST_HSA));
endmodule

// File: rtl/dvs_desc.sv
module dvs_desc
  import dvs_pkg::*;
#(
  parameter int WCW = 16
) (
  input  step_e           step,
  input  logic            first_sync,
  input  logic            last_sync,
  input  logic [1:0]      vc,
  input  logic [1:0]      pix_fmt,
  input  logic [WCW-1:0]  h_sync,
  input  logic [WCW-1:0]  h_bp,
  input  logic [WCW-1:0]  h_act,
  input  logic [WCW-1:0]  h_fp,
  input  logic [WCW-1:0]  fill_wc,
  output logic [7:0]      di,
  output logic [WCW-1:0]  wc,
  output kind_e           kind
);
  localparam int XW = WCW + 4;

  logic [XW-1:0]  a, x2, x3, x9q;
  logic [WCW-1:0] pix_wc;
  logic [5:0]     ptype;

  always_comb begin
    a   = XW'(h_act);
    x2  = a << 1;
    x3  = a + (a << 1);
    x9q = ((a << 3) + a) >> 2;
    case (pix_fmt)
      2'd0:    pix_wc = x2[WCW-1:0];
      2'd1:    pix_wc = x9q[WCW-1:0];
      default: pix_wc = x3[WCW-1:0];
    endcase
  end

  always_comb begin
    ptype = T_EOT;
    wc    = '0;
    kind  = K_NONE;
    case (step)
      ST_START: ptype = first_sync ? T_VS_START : T_HS_START;
      ST_END:   ptype = last_sync ? T_VS_END : T_HS_END;
      ST_HSA:   begin ptype = T_BLANK; wc = h_sync; kind = K_BLANK; end
      ST_HBP:   begin ptype = T_BLANK; wc = h_bp;   kind = K_BLANK; end
      ST_HFP:   begin ptype = T_BLANK; wc = h_fp;   kind = K_BLANK; end
      ST_PIX:   begin ptype = {pix_fmt, T_PIX_LO}; wc = pix_wc; kind = K_PIX; end
      ST_NULL:  begin ptype = T_NULL; wc = fill_wc; kind = K_NULL; end
      default:  ptype = T_EOT;
    endcase
    di = {vc, ptype};
  end
endmodule

// File: rtl/dvs_vid_sched.sv
module dvs_vid_sched
  import dvs_pkg::*;
#(
  parameter int WCW = 16,
  parameter int VW  = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [1:0]     mode,
  input  logic           hse,
  input  logic           skip_hsa,
  input  logic           skip_hbp,
  input  logic           skip_hfp,
  input  logic           auto_vcnt,
  input  logic           eot_off,
  input  logic [1:0]     vc,
  input  logic [1:0]     pix_fmt,
  input  logic [WCW-1:0] h_sync,
  input  logic [WCW-1:0] h_bp,
  input  logic [WCW-1:0] h_act,
  input  logic [WCW-1:0] h_fp,
  input  logic [VW-1:0]  v_sync,
  input  logic [VW-1:0]  v_bp,
  input  logic [VW-1:0]  v_act,
  input  logic [VW-1:0]  v_fp,
  input  logic [WCW-1:0] fill_wc,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [7:0]     out_di,
  output logic [WCW-1:0] out_wc,
  output logic [1:0]     out_kind
);
  logic  running, fire, clr, line_done;
  logic  line_active, first_sync, last_sync;
  step_e step;
  kind_e kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running <= 1'b0;
    else        running <= en;
  end

  assign clr       = !running;
  assign out_valid = running;
  assign fire      = out_valid && out_ready;

  dvs_vline #(.VW(VW)) u_vline (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(line_done),
    .auto_vcnt(auto_vcnt), .v_sync(v_sync), .v_bp(v_bp),
    .v_act(v_act), .v_fp(v_fp), .line_active(line_active),
    .first_sync(first_sync), .last_sync(last_sync)
  );

  dvs_step u_step (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fire(fire),
    .pulse(mode[1]), .burst(mode[0]), .hse(hse),
    .skip_hsa(skip_hsa), .skip_hbp(skip_hbp), .skip_hfp(skip_hfp),
    .eot_off(eot_off), .fill_nz(fill_wc != '0),
    .line_active(line_active), .step(step), .line_done(line_done)
  );

  dvs_desc #(.WCW(WCW)) u_desc (
    .step(step), .first_sync(first_sync), .last_sync(last_sync),
    .vc(vc), .pix_fmt(pix_fmt), .h_sync(h_sync), .h_bp(h_bp),
    .h_act(h_act), .h_fp(h_fp), .fill_wc(fill_wc),
    .di(out_di), .wc(out_wc), .kind(kind)
  );

  assign out_kind = kind;

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && en) |=>
      (out_valid && $stable(out_di) && $stable(out_wc) && $stable(out_kind)));

  // R11
  en_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out_valid);

  // R8
  eot_then_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && en && out_di[5:0] == T_EOT) |=>
      (out_di[5:0] == T_HS_START || out_di[5:0] == T_VS_START));
endmodule

// File: tb/sim_dvs_vid_sched.sv
module sim_dvs_vid_sched;
  localparam int WCW = 16;
  localparam int VW  = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n, en, hse, skip_hsa, skip_hbp, skip_hfp, auto_vcnt, eot_off;
  logic [1:0]     mode, vc, pix_fmt;
  logic [WCW-1:0] h_sync, h_bp, h_act, h_fp, fill_wc;
  logic [VW-1:0]  v_sync, v_bp, v_act, v_fp;
  logic           out_valid, out_ready;
  logic [7:0]     out_di;
  logic [WCW-1:0] out_wc;
  logic [1:0]     out_kind;

  dvs_vid_sched #(.WCW(WCW), .VW(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .hse(hse),
    .skip_hsa(skip_hsa), .skip_hbp(skip_hbp), .skip_hfp(skip_hfp),
    .auto_vcnt(auto_vcnt), .eot_off(eot_off), .vc(vc), .pix_fmt(pix_fmt),
    .h_sync(h_sync), .h_bp(h_bp), .h_act(h_act), .h_fp(h_fp),
    .v_sync(v_sync), .v_bp(v_bp), .v_act(v_act), .v_fp(v_fp),
    .fill_wc(fill_wc), .out_valid(out_valid), .out_ready(out_ready),
    .out_di(out_di), .out_wc(out_wc), .out_kind(out_kind)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [25:0] expq[$];

  task automatic chk(input bit ok, input string req, input logic [25:0] act, input logic [25:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [25:0] pk(input logic [5:0] t, input logic [15:0] w, input logic [1:0] k);
    return {vc, t, w, k};
  endfunction

  function automatic logic [15:0] pix_words();
    case (pix_fmt)
      2'd0:    return 16'(h_act * 2);
      2'd1:    return 16'((32'(h_act) * 9) / 4);
      default: return 16'(h_act * 3);
    endcase
  endfunction

  task automatic push_line(input bit act, input bit fs, input bit ls);
    expq.push_back(pk(fs ? 6'h01 : 6'h21, 16'd0, 2'd0));                       // R2
    if (mode[1] && !skip_hsa) expq.push_back(pk(6'h19, h_sync, 2'd1));          // R3
    if (mode[1] || (hse && !act)) expq.push_back(pk(ls ? 6'h11 : 6'h31, 16'd0, 2'd0)); // R3 R4
    if (act) begin
      if (!skip_hbp) expq.push_back(pk(6'h19, h_bp, 2'd1));                     // R5
      expq.push_back(pk({pix_fmt, 4'hE}, pix_words(), 2'd2));                   // R6
      if (!mode[0] && fill_wc != 0) expq.push_back(pk(6'h09, fill_wc, 2'd3));   // R7
      if (!skip_hfp) expq.push_back(pk(6'h19, h_fp, 2'd1));
    end
    if (!eot_off) expq.push_back(pk(6'h08, 16'd0, 2'd0));                       // R8
  endtask

  task automatic push_frame();
    int lens[4];
    lens[0] = auto_vcnt ? 0 : int'(v_sync);
    lens[1] = auto_vcnt ? 0 : int'(v_bp);
    lens[2] = int'(v_act);
    lens[3] = int'(v_fp);
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < lens[r]; i++)
        push_line(r == 2, r == 0 && i == 0, r == 0 && i == lens[r] - 1);   // R9
  endtask

  // consume n expected descriptors; stall=1 inserts back-pressure
  task automatic drain(input int n, input bit stall, input string req);
    int got = 0;
    int cyc = 0;
    bit held = 0;
    logic [25:0] hv = '0;
    logic [25:0] cur;
    while (got < n && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      out_ready = stall ? (cyc % 3 != 1) : 1'b1;
      cur = {out_di, out_wc, out_kind};
      if (held) chk(out_valid && cur == hv, "R10 hold", cur, hv);
      if (out_valid && out_ready) begin
        chk(cur == expq[0], req, cur, expq[0]);
        void'(expq.pop_front());
        got++;
      end
      held = out_valid && !out_ready;
      hv = cur;
    end
    if (got < n) chk(1'b0, "stream stalled", 26'(got), 26'(n));
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic set_base();
    mode = 2'b10; hse = 0; skip_hsa = 0; skip_hbp = 0; skip_hfp = 0;
    auto_vcnt = 0; eot_off = 0; vc = 2'd0; pix_fmt = 2'd3;
    h_sync = 16'd4; h_bp = 16'd6; h_act = 16'd8; h_fp = 16'd5; fill_wc = 16'd7;
    v_sync = 12'd2; v_bp = 12'd1; v_act = 12'd2; v_fp = 12'd1;
  endtask

  task automatic stop_run();
    @(negedge clk); en = 0;
    @(negedge clk);
    chk(!out_valid, "R11 en low", 26'(out_valid), 26'd0);
    expq.delete();
  endtask

  task automatic run_frames(input int nf, input bit stall, input string req);
    expq.delete();
    for (int f = 0; f < nf; f++) push_frame();
    @(negedge clk); en = 1;
    drain(expq.size(), stall, req);
    stop_run();
  endtask

  task automatic t_reset();
    rst_n = 0; en = 0; out_ready = 0; set_base();
    repeat (3) @(negedge clk);
    chk(!out_valid, "R12 reset", 26'(out_valid), 26'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!out_valid, "R12 idle", 26'(out_valid), 26'd0);
  endtask

  task automatic t_pulse_nb();
    set_base(); vc = 2'd1; pix_fmt = 2'd3;
    run_frames(2, 1'b0, "R1 R3 R5 R6 R7 R9 pulse non-burst");
  endtask

  task automatic t_event_burst();
    set_base(); mode = 2'b01; hse = 1; pix_fmt = 2'd0; vc = 2'd2; v_sync = 12'd1;
    run_frames(2, 1'b1, "R4 R7 R10 event burst hse");
  endtask

  task automatic t_event_skip();
    set_base(); mode = 2'b00; skip_hsa = 1; skip_hbp = 1; skip_hfp = 1;
    eot_off = 1; pix_fmt = 2'd2; vc = 2'd3; v_bp = 12'd0;
    run_frames(2, 1'b0, "R4 R5 R8 skips no eot");
  endtask

  task automatic t_auto_pulse();
    set_base(); auto_vcnt = 1; pix_fmt = 2'd1; mode = 2'b11; skip_hsa = 1; fill_wc = 16'd0;
    run_frames(2, 1'b1, "R6 R9 auto vertical burst");
  endtask

  task automatic t_restart();
    set_base();
    expq.delete(); push_frame();
    @(negedge clk); en = 1;
    drain(5, 1'b0, "R11 before stop");
    stop_run();
    push_frame();
    @(negedge clk); en = 1;
    drain(expq.size(), 1'b0, "R11 restart at frame start");
    stop_run();
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_pulse_nb();
    t_event_burst();
    t_event_skip();
    t_auto_pulse();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule